// File: doc/BRIEF.md
# Multicycle RV32 Datapath

This block is the storage and arithmetic half of a multicycle processor for a small RV32 subset: register-register ALU operations, word load, word store and branch-if-equal. An external step controller drives its control inputs one clock at a time. The datapath has one memory that holds both code and data, and one ALU that is used again in every step. The same ALU computes the next PC, the speculative branch target, the R-type result, the load/store address and the equality compare. Holding registers carry values from one step to the next: the instruction register, the memory data register, the two operand latches and the ALU result register.

The controller reads the opcode, funct3 and funct7 fields and the ALU zero flag to choose its next step. For observation, the block also exposes the current PC and the ALU result register. The memory is a small internal word array. On reset it is filled with a fixed computed pattern, so the datapath runs without any loading path.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high reset sets PC, IR, A, B, MDR, ALUOut and all 32 registers to zero, and sets memory word i to (i * 0x9E3779B1) mod 2^32.
- R2: The memory address is PC when `iord` is 0 and ALUOut when it is 1. The word index is address bits [7:2] with the default 64 words, so the address wraps.
- R3: IR captures the memory read data only on an edge where `ir_wr` is 1 and otherwise holds. `opcode` shows IR[6:0], `funct3` shows IR[14:12] and `funct7` shows IR[31:25].
- R4: ALU operand A is PC when `alu_src_a` is 0 and register A when it is 1. Operand B is register B for `alu_src_b`=0, the constant 4 for 1, the immediate for 2, and zero for 3.
- R5: `alu_op` 0 adds, 1 subtracts (B from A), and 3 adds. For `alu_op` 2 the operation follows funct3: 0 is add, or sub if funct7[5] is set; 1 is sll; 2 is signed slt; 3 is sltu; 4 is xor; 5 is srl, or sra if funct7[5] is set; 6 is or; 7 is and. Shift amounts use operand B bits [4:0].
- R6: The immediate is chosen by IR[6:0]. Opcode 0100011 gives the store format {IR[31:25],IR[11:7]}. Opcode 1100011 gives the branch format {IR[31],IR[7],IR[30:25],IR[11:8],0}, which is already doubled. Every other opcode gives IR[31:20]. All three are sign-extended.
- R7: A and B load the registers indexed by IR[19:15] and IR[24:20], MDR loads the memory read data, and ALUOut loads the ALU result, all on every clock edge. `alu_out` shows ALUOut.
- R8: On an edge with `pc_wr` set, PC loads the ALU result. Otherwise, with `pc_wr_cond` set and `zero` high, PC loads ALUOut. In all other cases PC holds.
- R9: With `reg_wr` set, the register indexed by IR[11:7] is written with MDR when `mem_to_reg` is 1 and with ALUOut when it is 0. A write to x0 is dropped and x0 always reads as zero.
- R10: With `mem_wr` set, B is written to the addressed word at the edge. The read data is that word while `mem_rd` is 1 and zero while it is 0. A read in the same cycle as a write returns the old word.
- R11: `zero` is high exactly when the current combinational ALU result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iord | input | 1 | Memory address select: 0 PC, 1 ALUOut |
| mem_rd | input | 1 | Memory read enable |
| mem_wr | input | 1 | Memory write enable |
| ir_wr | input | 1 | Instruction register load enable |
| reg_wr | input | 1 | Register file write enable |
| mem_to_reg | input | 1 | Writeback select: 0 ALUOut, 1 MDR |
| alu_src_a | input | 1 | ALU A select: 0 PC, 1 A |
| alu_src_b | input | 2 | ALU B select: B, 4, immediate, zero |
| alu_op | input | 2 | ALU operation class |
| pc_wr | input | 1 | Unconditional PC write from ALU result |
| pc_wr_cond | input | 1 | PC write from ALUOut when zero is high |
| opcode | output | 7 | IR[6:0] |
| funct3 | output | 3 | IR[14:12] |
| funct7 | output | 7 | IR[31:25] |
| zero | output | 1 | ALU result equals zero |
| pc | output | 32 | Current PC |
| alu_out | output | 32 | ALU result register |

## Verification
The hardest state to reach from the ports is a register or memory word holding a value that was written earlier and is then read back through A, B or MDR. The only way to see such a value is to send it through the ALU into ALUOut. The bench drives long runs of random control words, so stores, register writebacks and operand loads interleave in arbitrary orders. A reference model of the memory, the register file and the holding registers predicts every ALUOut, PC, zero flag and field output. Directed steps cover fetch, a fetch with read disabled, and the conflict where both PC write enables are set.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN = 32;
    localparam logic [XLEN-1:0] MEM_SEED_MUL = 32'h9E37_79B1;

    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'd0,
        ALU_SUB   = 2'd1,
        ALU_FUNCT = 2'd2,
        ALU_ADD2  = 2'd3
    } alu_class_e;

    typedef enum logic [1:0] {
        SRCB_REG  = 2'd0,
        SRCB_FOUR = 2'd1,
        SRCB_IMM  = 2'd2,
        SRCB_ZERO = 2'd3
    } srcb_e;

    typedef struct packed {
        logic [6:0] funct7;
        logic [4:0] rs2;
        logic [4:0] rs1;
        logic [2:0] funct3;
        logic [4:0] rd;
        logic [6:0] opcode;
    } instr_t;

    function automatic logic [XLEN-1:0] mem_seed(input int unsigned idx);
        logic [XLEN-1:0] w;
        w = XLEN'(idx) * MEM_SEED_MUL;
        return w;
    endfunction

endpackage

// File: rtl/mc_memory.sv
module mc_memory
    import mc_pkg::*;
#(
    parameter int MEM_WORDS = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] addr,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);
    localparam int IDX_W = $clog2(MEM_WORDS);

    logic [XLEN-1:0] words [MEM_WORDS];
    logic [IDX_W-1:0] idx;
    logic             unused_addr_bits;

    assign idx              = addr[IDX_W+1:2];
    assign unused_addr_bits = ^{addr[XLEN-1:IDX_W+2], addr[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_WORDS; i++) begin
                words[i] <= mem_seed(i);
            end
        end else if (wr_en) begin
            words[idx] <= wdata;
        end
    end

    assign rdata = rd_en ? words[idx] : '0;

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(NUM_REGS)-1:0] raddr1,
    input  logic [$clog2(NUM_REGS)-1:0] raddr2,
    input  logic                        we,
    input  logic [$clog2(NUM_REGS)-1:0] waddr,
    input  logic [XLEN-1:0]             wdata,
    output logic [XLEN-1:0]             rdata1,
    output logic [XLEN-1:0]             rdata2
);
    logic [XLEN-1:0] regs [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata1 = (raddr1 == '0) ? '0 : regs[raddr1];
    assign rdata2 = (raddr2 == '0) ? '0 : regs[raddr2];

endmodule

// File: rtl/mc_immgen.sv
module mc_immgen
    import mc_pkg::*;
(
    input  instr_t          ir,
    output logic [XLEN-1:0] imm
);
    logic [31:0] raw;
    logic        unused_mid;

    assign raw        = ir;
    assign unused_mid = ^raw[19:12];

    always_comb begin
        unique case (ir.opcode)
            OPC_STORE:  imm = {{20{raw[31]}}, raw[31:25], raw[11:7]};
            OPC_BRANCH: imm = {{19{raw[31]}}, raw[31], raw[7], raw[30:25], raw[11:8], 1'b0};
            default:    imm = {{20{raw[31]}}, raw[31:20]};
        endcase
    end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
(
    input  alu_class_e      op_class,
    input  logic [2:0]      funct3,
    input  logic [6:0]      funct7,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    logic [4:0] shamt;
    logic       alt;
    logic       unused_f7;

    assign shamt     = b[4:0];
    assign alt       = funct7[5];
    assign unused_f7 = ^{funct7[6], funct7[4:0]};

    always_comb begin
        unique case (op_class)
            ALU_SUB: y = a - b;
            ALU_FUNCT: begin
                unique case (funct3)
                    3'd0:    y = alt ? (a - b) : (a + b);
                    3'd1:    y = a << shamt;
                    3'd2:    y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
                    3'd3:    y = {{(XLEN-1){1'b0}}, (a < b)};
                    3'd4:    y = a ^ b;
                    3'd5:    y = alt ? XLEN'($signed(a) >>> shamt) : (a >> shamt);
                    3'd6:    y = a | b;
                    default: y = a & b;
                endcase
            end
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int MEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        iord,
    input  logic        mem_rd,
    input  logic        mem_wr,
    input  logic        ir_wr,
    input  logic        reg_wr,
    input  logic        mem_to_reg,
    input  logic        alu_src_a,
    input  logic [1:0]  alu_src_b,
    input  logic [1:0]  alu_op,
    input  logic        pc_wr,
    input  logic        pc_wr_cond,
    output logic [6:0]  opcode,
    output logic [2:0]  funct3,
    output logic [6:0]  funct7,
    output logic        zero,
    output logic [31:0] pc,
    output logic [31:0] alu_out
);
    localparam int NUM_REGS = 32;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
    logic [XLEN-1:0] mem_addr, mem_rdata, imm, op_a, op_b, alu_res, wb_data;
    logic [XLEN-1:0] rf_rd1, rf_rd2;
    instr_t          ir_f;
    srcb_e           srcb_sel;

    assign ir_f     = instr_t'(ir_q);
    assign srcb_sel = srcb_e'(alu_src_b);
    assign mem_addr = iord ? alu_out_q : pc_q;
    assign wb_data  = mem_to_reg ? mdr_q : alu_out_q;

    mc_memory #(.MEM_WORDS(MEM_WORDS)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .addr  (mem_addr),
        .rd_en (mem_rd),
        .wr_en (mem_wr),
        .wdata (b_q),
        .rdata (mem_rdata)
    );

    mc_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .raddr1 (ir_f.rs1),
        .raddr2 (ir_f.rs2),
        .we     (reg_wr),
        .waddr  (ir_f.rd),
        .wdata  (wb_data),
        .rdata1 (rf_rd1),
        .rdata2 (rf_rd2)
    );

    mc_immgen u_imm (
        .ir  (ir_f),
        .imm (imm)
    );

    assign op_a = alu_src_a ? a_q : pc_q;

    always_comb begin
        unique case (srcb_sel)
            SRCB_REG:  op_b = b_q;
            SRCB_FOUR: op_b = STEP;
            SRCB_IMM:  op_b = imm;
            default:   op_b = '0;
        endcase
    end

    mc_alu u_alu (
        .op_class (alu_class_e'(alu_op)),
        .funct3   (ir_f.funct3),
        .funct7   (ir_f.funct7),
        .a        (op_a),
        .b        (op_b),
        .y        (alu_res),
        .zero     (zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
        end else if (ir_wr) begin
            ir_q <= mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q       <= '0;
            b_q       <= '0;
            mdr_q     <= '0;
            alu_out_q <= '0;
        end else begin
            a_q       <= rf_rd1;
            b_q       <= rf_rd2;
            mdr_q     <= mem_rdata;
            alu_out_q <= alu_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (pc_wr) begin
            pc_q <= alu_res;
        end else if (pc_wr_cond && zero) begin
            pc_q <= alu_out_q;
        end
    end

    assign opcode  = ir_f.opcode;
    assign funct3  = ir_f.funct3;
    assign funct7  = ir_f.funct7;
    assign pc      = pc_q;
    assign alu_out = alu_out_q;

endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
    input logic        clk,
    input logic        rst,
    input logic        pc_wr,
    input logic        pc_wr_cond,
    input logic        ir_wr,
    input logic        zero,
    input logic [31:0] pc_q,
    input logic [31:0] ir_q,
    input logic [31:0] a_q,
    input logic [31:0] alu_res,
    input logic [31:0] alu_out_q
);
    // R8
    pc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc_q));

    // R8
    pc_uncond_chk: assert property (@(posedge clk) disable iff (rst)
        pc_wr |=> (pc_q == $past(alu_res)));

    // R8
    pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && pc_wr_cond && zero) |=> (pc_q == $past(alu_out_q)));

    // R3
    ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> $stable(ir_q));

    // R7
    aluout_load_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (alu_out_q == $past(alu_res)));

    // R9
    x0_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_q[19:15] == 5'd0) |=> (a_q == 32'd0));

endmodule

bind mc_datapath mc_datapath_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .ir_wr      (ir_wr),
    .zero       (zero),
    .pc_q       (pc_q),
    .ir_q       (ir_q),
    .a_q        (a_q),
    .alu_res    (alu_res),
    .alu_out_q  (alu_out_q)
);

// File: tb/mc_datapath_tb.sv
module mc_datapath_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEMW = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iord = 0, mem_rd = 0, mem_wr = 0, ir_wr = 0, reg_wr = 0, mem_to_reg = 0;
    logic alu_src_a = 0, pc_wr = 0, pc_wr_cond = 0;
    logic [1:0] alu_src_b = 0, alu_op = 0;
    logic [6:0] opcode, funct7;
    logic [2:0] funct3;
    logic zero;
    logic [31:0] pc, alu_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] m_mem [MEMW];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc, m_ir, m_a, m_b, m_mdr, m_aluout;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_datapath u_dut (
        .clk(clk), .rst(rst), .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_wr(ir_wr), .reg_wr(reg_wr), .mem_to_reg(mem_to_reg),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .opcode(opcode),
        .funct3(funct3), .funct7(funct7), .zero(zero), .pc(pc), .alu_out(alu_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_imm(input logic [31:0] i);
        if (i[6:0] == 7'b0100011) return {{20{i[31]}}, i[31:25], i[11:7]};
        if (i[6:0] == 7'b1100011) return {{19{i[31]}}, i[31], i[7], i[30:25], i[11:8], 1'b0};
        return {{20{i[31]}}, i[31:20]};
    endfunction

    function automatic logic [31:0] ref_alu(input logic [1:0] op, input logic [31:0] i,
                                            input logic [31:0] a, input logic [31:0] b);
        logic alt;
        alt = i[30];
        if (op == 2'd1) return a - b;
        if (op != 2'd2) return a + b;
        case (i[14:12])
            3'd0: return alt ? a - b : a + b;
            3'd1: return a << b[4:0];
            3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'd3: return (a < b) ? 32'd1 : 32'd0;
            3'd4: return a ^ b;
            3'd5: return alt ? 32'($signed(a) >>> b[4:0]) : a >> b[4:0];
            3'd6: return a | b;
            default: return a & b;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < MEMW; i++) m_mem[i] = 32'(i) * 32'h9E37_79B1;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        m_pc = 0; m_ir = 0; m_a = 0; m_b = 0; m_mdr = 0; m_aluout = 0;
    endtask

    task automatic step(input logic i_iord, input logic i_rd, input logic i_wr,
                        input logic i_irw, input logic i_rw, input logic i_m2r,
                        input logic i_sa, input logic [1:0] i_sb, input logic [1:0] i_op,
                        input logic i_pw, input logic i_pwc, input string tag);
        logic [31:0] addr, rdata, opa, opb, res;
        logic        z;
        int          idx;
        @(negedge clk);
        iord = i_iord; mem_rd = i_rd; mem_wr = i_wr; ir_wr = i_irw; reg_wr = i_rw;
        mem_to_reg = i_m2r; alu_src_a = i_sa; alu_src_b = i_sb; alu_op = i_op;
        pc_wr = i_pw; pc_wr_cond = i_pwc;
        #1;
        addr  = i_iord ? m_aluout : m_pc;
        idx   = int'(addr[7:2]);
        rdata = i_rd ? m_mem[idx] : 32'd0;
        opa   = i_sa ? m_a : m_pc;
        case (i_sb)
            2'd0: opb = m_b;
            2'd1: opb = 32'd4;
            2'd2: opb = ref_imm(m_ir);
            default: opb = 32'd0;
        endcase
        res = ref_alu(i_op, m_ir, opa, opb);
        z   = (res == 32'd0);
        chk({tag, " R11 zero"}, {31'd0, zero}, {31'd0, z});
        chk({tag, " R3 fields"}, {8'd0, funct7, funct3, opcode},
            {8'd0, m_ir[31:25], m_ir[14:12], m_ir[6:0]});
        if (i_rw && m_ir[11:7] != 5'd0) m_rf[m_ir[11:7]] = i_m2r ? m_mdr : m_aluout;
        if (i_pw) m_pc = res;
        else if (i_pwc && z) m_pc = m_aluout;
        m_a = (m_ir[19:15] == 0) ? 32'd0 : m_rf_old(m_ir[19:15], i_rw, m_ir[11:7]);
        m_b = (m_ir[24:20] == 0) ? 32'd0 : m_rf_old(m_ir[24:20], i_rw, m_ir[11:7]);
        if (i_wr) m_mem[idx] = m_b_old;
        m_mdr    = rdata;
        m_aluout = res;
        if (i_irw) m_ir = rdata;
        @(posedge clk);
        #1;
        chk({tag, " R8 pc"}, pc, m_pc);
        chk({tag, " R2 R4 R5 R6 R7 R9 R10 aluout"}, alu_out, m_aluout);
    endtask

    // Register values before the edge: a write at this edge is not yet visible to A/B.
    logic [31:0] rf_snap [32];
    logic [31:0] m_b_old;
    function automatic logic [31:0] m_rf_old(input logic [4:0] r, input logic w, input logic [4:0] rd);
        if (w) return rf_snap[r];
        return m_rf[r];
    endfunction

    task automatic rstep(input string tag, input logic [1:0] sb, input logic [1:0] op,
                         input logic irw, input logic rd);
        for (int i = 0; i < 32; i++) rf_snap[i] = m_rf[i];
        m_b_old = m_b;
        step(1'($urandom), rd, ($urandom % 4) == 0, irw, 1'($urandom), 1'($urandom),
             1'($urandom), sb, op, ($urandom % 3) == 0, 1'($urandom), tag);
    endtask

    task automatic dstep(input logic i_iord, input logic i_rd, input logic i_wr,
                         input logic i_irw, input logic i_rw, input logic i_m2r,
                         input logic i_sa, input logic [1:0] i_sb, input logic [1:0] i_op,
                         input logic i_pw, input logic i_pwc, input string tag);
        for (int i = 0; i < 32; i++) rf_snap[i] = m_rf[i];
        m_b_old = m_b;
        step(i_iord, i_rd, i_wr, i_irw, i_rw, i_m2r, i_sa, i_sb, i_op, i_pw, i_pwc, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 pc after reset", pc, 32'd0);
        chk("R1 aluout after reset", alu_out, 32'd0);
        chk("R1 opcode after reset", {25'd0, opcode}, 32'd0);
        // fetch from word 0 (seed 0), PC+4
        dstep(0, 1, 0, 1, 0, 0, 0, 2'd1, 2'd0, 1, 0, "R1 R2 fetch0");
        // fetch from word 1 (seed 0x9E3779B1)
        dstep(0, 1, 0, 1, 0, 0, 0, 2'd1, 2'd0, 1, 0, "R1 R2 fetch1");
        chk("R1 R3 opcode of word1", {25'd0, opcode}, 32'h31);
        // decode-style: ALUOut = PC + imm
        dstep(0, 1, 0, 0, 0, 0, 0, 2'd2, 2'd0, 0, 0, "R6 target");
        // read disabled: IR captures zero
        dstep(0, 0, 0, 1, 0, 0, 0, 2'd0, 2'd0, 0, 0, "R10 read off");
        chk("R10 opcode zero after read off", {25'd0, opcode}, 32'd0);
        // both PC enables, unconditional wins
        dstep(0, 1, 0, 0, 0, 0, 0, 2'd1, 2'd0, 1, 1, "R8 priority");
        // conditional with zero: operand B zero, PC 0? use sub PC-PC not possible; A=0 sub zero
        dstep(0, 1, 0, 0, 0, 0, 1, 2'd3, 2'd1, 0, 1, "R8 branch taken");
        // write attempt to x0 (IR is zero so rd=0)
        dstep(0, 1, 0, 0, 1, 0, 0, 2'd1, 2'd0, 0, 0, "R9 x0 write");
        dstep(0, 1, 0, 0, 0, 0, 1, 2'd3, 2'd0, 0, 0, "R9 x0 read");
        for (int n = 0; n < 4000; n++) begin
            rstep("random", 2'($urandom), 2'($urandom), ($urandom % 3) == 0, ($urandom % 5) != 0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule